// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupts

This block is a word-addressed memory with two fully independent ports, named left and right. Each port has its own select, write strobe, output enable, address and data lines, so both sides can read or write any word in the same clock cycle. The whole block runs on one clock. A read is registered: its data appears on the port one cycle after the request, together with a drive-enable that tells the pad logic when to drive the bus. While the drive-enable is low the data output is held at zero, which stands for a high-impedance bus.

The two highest addresses also act as message boxes between the ports. When the right port writes the word just below the top, the left port gets an interrupt. When the left port writes the top word, the right port gets one. The receiving port clears its interrupt by reading its own message box. The eight-bit content of each box is ordinary stored data. A write-block input on each port comes from external collision arbitration and suppresses that port's writes. A blocked write changes neither the memory nor the interrupt flags. A parameter removes the interrupt logic, and the two top words then act as plain memory.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: During and right after reset, both interrupt outputs are high (inactive) and both read drive-enables are low.
- R2: A port writes `wdata` to `addr` at the clock edge where its select is low, its write strobe is low and its write-block input is high. A read request has select low, write strobe high and output enable low. It makes `rdata` carry the word stored at `addr` and `rdoe` go high in the cycle after the request.
- R3: A port whose select is high is in standby. Its standby output is high, it writes nothing, and in the next cycle `rdoe` is low and `rdata` is zero.
- R4: A selected port whose write strobe and output enable are both high does not drive. In the next cycle `rdoe` is low and `rdata` is zero.
- R5: The left message box is address 2^ADDR_W-2 (0x1FFE by default). A write there by the right port drives `l_irq_n` low from the next cycle. A read there by the left port returns it high from the next cycle.
- R6: The right message box is address 2^ADDR_W-1 (0x1FFF by default). A write there by the left port drives `r_irq_n` low from the next cycle. A read there by the right port returns it high from the next cycle.
- R7: Message box contents are stored and read back like any other word. A port writing its own box, or reading the other port's box, leaves both flags unchanged.
- R8: A write attempt while the port's write-block input is low leaves the memory unchanged. It also leaves the opposite port's interrupt unchanged, even when the address is a message box.
- R9: If both ports write the same address in one cycle, the word holds the left port's data afterwards.
- R10: If a message box write that sets a flag and the owning port's clearing read fall in the same cycle, the flag ends set.
- R11: With MAILBOX_ON = 0, both interrupt outputs stay high, and the two top addresses store and return data like any other word.
- R12: A read in the same cycle as a write by the other port to the same address returns the word as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en_n | input | 1 | Left port select, active low |
| l_we_n | input | 1 | Left port write strobe, active low |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_wr_block_n | input | 1 | Left write block from arbitration, low suppresses writes |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port read data, zero when not driving |
| l_rdoe | output | 1 | Left port bus drive enable |
| l_irq_n | output | 1 | Left interrupt, active low, registered |
| l_standby | output | 1 | Left port deselected |
| r_en_n | input | 1 | Right port select, active low |
| r_we_n | input | 1 | Right port write strobe, active low |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_wr_block_n | input | 1 | Right write block from arbitration, low suppresses writes |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port read data, zero when not driving |
| r_rdoe | output | 1 | Right port bus drive enable |
| r_irq_n | output | 1 | Right interrupt, active low, registered |
| r_standby | output | 1 | Right port deselected |

## Verification
The hardest case to reach is two things landing on a message box in the same edge: the sender's write, which sets a flag, and the owner's read, which clears it. The read must also return the old word while the flag stays set. The bench gets there by driving both ports at once in one cycle, with a known earlier value already in the box. It then follows with a lone read that returns the new word and clears the flag. A second instance, built without the interrupt logic, takes the same stimulus. It shows that the box addresses stay plain memory and that its flags never move.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    // What a port does in the current cycle, decoded from its strobes
    typedef enum logic [2:0] {
        ACC_OFF    = 3'd0,  // deselected, standby
        ACC_QUIET  = 3'd1,  // selected, neither reading nor writing
        ACC_READ   = 3'd2,  // read with output enabled
        ACC_WRITE  = 3'd3,  // write that takes effect
        ACC_WBLOCK = 3'd4   // write suppressed by arbitration
    } acc_t;

    localparam int NPORT = 2;  // index 0 = left, index 1 = right

endpackage

// File: rtl/dpm_port_dec.sv
module dpm_port_dec
    import dpm_pkg::*;
(
    input  logic en_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic blk_n,
    output acc_t kind,
    output logic standby
);

    always_comb begin
        if (en_n) begin
            kind = ACC_OFF;
        end else if (!we_n) begin
            kind = blk_n ? ACC_WRITE : ACC_WBLOCK;
        end else if (!oe_n) begin
            kind = ACC_READ;
        end else begin
            kind = ACC_QUIET;
        end
        standby = (kind == ACC_OFF);
    end

endmodule

// File: rtl/dpm_store.sv
module dpm_store
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  acc_t [NPORT-1:0]              kind,
    input  logic [NPORT-1:0][ADDR_W-1:0]  addr,
    input  logic [NPORT-1:0][DATA_W-1:0]  wdata,
    output logic [NPORT-1:0][DATA_W-1:0]  rdata,
    output logic [NPORT-1:0]              rdoe
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [NPORT-1:0]             oe;
        logic [NPORT-1:0][DATA_W-1:0] dat;
    } rd_t;

    logic [DATA_W-1:0] mem [DEPTH];
    rd_t rd_d, rd_q;

    // Right is written first and left last, so on the same address the
    // left data is the one that remains.
    always_ff @(posedge clk) begin
        if (kind[1] == ACC_WRITE) mem[addr[1]] <= wdata[1];
        if (kind[0] == ACC_WRITE) mem[addr[0]] <= wdata[0];
    end

    // Reads sample the array before this edge's writes: old data wins
    always_comb begin
        rd_d = '0;
        for (int p = 0; p < NPORT; p++) begin
            rd_d.oe[p]  = (kind[p] == ACC_READ);
            rd_d.dat[p] = rd_d.oe[p] ? mem[addr[p]] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q.dat;
    assign rdoe  = rd_q.oe;

endmodule

// File: rtl/dpm_irq.sv
module dpm_irq
    import dpm_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter bit MAILBOX_ON = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  acc_t [NPORT-1:0]              kind,
    input  logic [NPORT-1:0][ADDR_W-1:0]  addr,
    output logic [NPORT-1:0]              irq_n
);

    // Box owned by port p: all ones except bit 0, which equals p
    function automatic logic [ADDR_W-1:0] box_of(input int p);
        return {{(ADDR_W-1){1'b1}}, p[0]};
    endfunction

    generate
        if (MAILBOX_ON) begin : g_on
            typedef struct packed {
                logic [NPORT-1:0] flag;
            } st_t;

            st_t              st_d, st_q;
            logic [NPORT-1:0] set_hit, clr_hit;

            always_comb begin
                st_d = st_q;
                for (int p = 0; p < NPORT; p++) begin
                    set_hit[p] = (kind[NPORT-1-p] == ACC_WRITE) &&
                                 (addr[NPORT-1-p] == box_of(p));
                    clr_hit[p] = (kind[p] == ACC_READ) &&
                                 (addr[p] == box_of(p));
                    if (set_hit[p])      st_d.flag[p] = 1'b1;  // set wins
                    else if (clr_hit[p]) st_d.flag[p] = 1'b0;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign irq_n = ~st_q.flag;
        end else begin : g_off
            assign irq_n = '1;
        end
    endgenerate

endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram
    import dpm_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter bit MAILBOX_ON = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic              l_wr_block_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rdoe,
    output logic              l_irq_n,
    output logic              l_standby,
    input  logic              r_en_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic              r_wr_block_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rdoe,
    output logic              r_irq_n,
    output logic              r_standby
);

    logic [NPORT-1:0]             en_n, we_n, oe_n, blk_n, stby, rdoe, irq_n;
    logic [NPORT-1:0][ADDR_W-1:0] addr;
    logic [NPORT-1:0][DATA_W-1:0] wdata, rdata;
    acc_t [NPORT-1:0]             kind;

    assign en_n  = {r_en_n, l_en_n};
    assign we_n  = {r_we_n, l_we_n};
    assign oe_n  = {r_oe_n, l_oe_n};
    assign blk_n = {r_wr_block_n, l_wr_block_n};
    assign addr  = {r_addr, l_addr};
    assign wdata = {r_wdata, l_wdata};

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_port
            dpm_port_dec u_dec (
                .en_n    (en_n[g]),
                .we_n    (we_n[g]),
                .oe_n    (oe_n[g]),
                .blk_n   (blk_n[g]),
                .kind    (kind[g]),
                .standby (stby[g])
            );
        end
    endgenerate

    dpm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .rdoe  (rdoe)
    );

    dpm_irq #(.ADDR_W(ADDR_W), .MAILBOX_ON(MAILBOX_ON)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .addr  (addr),
        .irq_n (irq_n)
    );

    assign l_rdata   = rdata[0];
    assign r_rdata   = rdata[1];
    assign l_rdoe    = rdoe[0];
    assign r_rdoe    = rdoe[1];
    assign l_irq_n   = irq_n[0];
    assign r_irq_n   = irq_n[1];
    assign l_standby = stby[0];
    assign r_standby = stby[1];

endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter bit MAILBOX_ON = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_en_n,
    input logic              l_we_n,
    input logic              l_oe_n,
    input logic              l_wr_block_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_rdoe,
    input logic              l_irq_n,
    input logic              r_en_n,
    input logic              r_we_n,
    input logic              r_oe_n,
    input logic              r_wr_block_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_rdoe,
    input logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};

    // R3: a deselected port does not drive in the following cycle
    a_r3_left_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        l_en_n |=> !l_rdoe);
    a_r3_right_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        r_en_n |=> !r_rdoe);

    // R4: selected, no write, output disabled -> no drive
    a_r4_left_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_en_n && l_we_n && l_oe_n) |=> !l_rdoe);
    a_r4_right_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_en_n && r_we_n && r_oe_n) |=> !r_rdoe);

    // R2: a read request drives the bus the next cycle
    a_r2_left_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_en_n && l_we_n && !l_oe_n) |=> l_rdoe);
    a_r2_right_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_en_n && r_we_n && !r_oe_n) |=> r_rdoe);
    a_r2_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_rdoe |-> l_rdata == '0) and (!r_rdoe |-> r_rdata == '0));

    generate
        if (MAILBOX_ON) begin : g_box
            a_r5_left_set: assert property (@(posedge clk) disable iff (!rst_n)
                (!r_en_n && !r_we_n && r_wr_block_n && r_addr == BOX_L) |=> !l_irq_n);
            a_r5_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (!l_en_n && l_we_n && !l_oe_n && l_addr == BOX_L &&
                 !(!r_en_n && !r_we_n && r_wr_block_n && r_addr == BOX_L)) |=> l_irq_n);
            a_r6_right_set: assert property (@(posedge clk) disable iff (!rst_n)
                (!l_en_n && !l_we_n && l_wr_block_n && l_addr == BOX_R) |=> !r_irq_n);
            a_r6_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (!r_en_n && r_we_n && !r_oe_n && r_addr == BOX_R &&
                 !(!l_en_n && !l_we_n && l_wr_block_n && l_addr == BOX_R)) |=> r_irq_n);
            // R8: a blocked write to a box never raises the flag
            a_r8_blocked_no_set_left: assert property (@(posedge clk) disable iff (!rst_n)
                (!r_en_n && !r_we_n && !r_wr_block_n && r_addr == BOX_L && l_irq_n) |=> l_irq_n);
            a_r8_blocked_no_set_right: assert property (@(posedge clk) disable iff (!rst_n)
                (!l_en_n && !l_we_n && !l_wr_block_n && l_addr == BOX_R && r_irq_n) |=> r_irq_n);
        end else begin : g_nobox
            a_r11_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
                l_irq_n && r_irq_n);
        end
    endgenerate

endmodule

bind dpm_mailbox_ram dpm_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAILBOX_ON(MAILBOX_ON)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_en_n(l_en_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_wr_block_n(l_wr_block_n),
    .l_addr(l_addr), .l_rdata(l_rdata), .l_rdoe(l_rdoe), .l_irq_n(l_irq_n),
    .r_en_n(r_en_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_wr_block_n(r_wr_block_n),
    .r_addr(r_addr), .r_rdata(r_rdata), .r_rdoe(r_rdoe), .r_irq_n(r_irq_n)
);

// File: tb/sim_dpm_mailbox_ram.sv
`timescale 1ns/1ps
module sim_dpm_mailbox_ram;

    localparam int AW = 13;
    localparam int DW = 8;
    localparam logic [AW-1:0] BOX_L = 13'h1FFE;
    localparam logic [AW-1:0] BOX_R = 13'h1FFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic          l_en_n, l_we_n, l_oe_n, l_blk_n, r_en_n, r_we_n, r_oe_n, r_blk_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata;
    logic [DW-1:0] l_rdata, r_rdata, l_rdata1, r_rdata1;
    logic          l_rdoe, r_rdoe, l_irq_n, r_irq_n, l_stby, r_stby;
    logic          l_rdoe1, r_rdoe1, l_irq_n1, r_irq_n1, l_stby1, r_stby1;

    dpm_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW), .MAILBOX_ON(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n),
        .l_en_n(l_en_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_wr_block_n(l_blk_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rdoe(l_rdoe),
        .l_irq_n(l_irq_n), .l_standby(l_stby),
        .r_en_n(r_en_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_wr_block_n(r_blk_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rdoe(r_rdoe),
        .r_irq_n(r_irq_n), .r_standby(r_stby));

    dpm_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW), .MAILBOX_ON(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n),
        .l_en_n(l_en_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_wr_block_n(l_blk_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata1), .l_rdoe(l_rdoe1),
        .l_irq_n(l_irq_n1), .l_standby(l_stby1),
        .r_en_n(r_en_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_wr_block_n(r_blk_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata1), .r_rdoe(r_rdoe1),
        .r_irq_n(r_irq_n1), .r_standby(r_stby1));

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic idle();
        l_en_n = 1; l_we_n = 1; l_oe_n = 1; l_blk_n = 1; l_addr = '0; l_wdata = '0;
        r_en_n = 1; r_we_n = 1; r_oe_n = 1; r_blk_n = 1; r_addr = '0; r_wdata = '0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_wr(input bit right, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic blk_n);
        if (right) begin r_en_n = 0; r_we_n = 0; r_addr = a; r_wdata = d; r_blk_n = blk_n; end
        else       begin l_en_n = 0; l_we_n = 0; l_addr = a; l_wdata = d; l_blk_n = blk_n; end
    endtask

    task automatic set_rd(input bit right, input logic [AW-1:0] a);
        if (right) begin r_en_n = 0; r_oe_n = 0; r_addr = a; end
        else       begin l_en_n = 0; l_oe_n = 0; l_addr = a; end
    endtask

    task automatic wr(input bit right, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic blk_n);
        idle(); set_wr(right, a, d, blk_n); step(); idle();
    endtask

    task automatic rd(input bit right, input logic [AW-1:0] a, output logic [DW-1:0] d);
        idle(); set_rd(right, a); step();
        d = right ? r_rdata : l_rdata;
        chk("R2 rdoe on read", right ? r_rdoe : l_rdoe, 1);
        idle();
    endtask

    task automatic t_reset();
        chk("R1 l_irq_n in reset", l_irq_n, 1);
        chk("R1 r_irq_n in reset", r_irq_n, 1);
        chk("R1 rdoe in reset", {l_rdoe, r_rdoe}, 0);
        step(); rst_n = 1; step();
        chk("R1 irq after reset", {l_irq_n, r_irq_n}, 2'b11);
        chk("R3 standby when deselected", {l_stby, r_stby}, 2'b11);
    endtask

    task automatic t_basic();
        logic [DW-1:0] d;
        wr(0, 13'h0123, 8'hA5, 1);
        rd(1, 13'h0123, d); chk("R2 right reads left write", d, 8'hA5);
        wr(1, 13'h0456, 8'h3C, 1);
        rd(0, 13'h0456, d); chk("R2 left reads right write", d, 8'h3C);
    endtask

    task automatic t_deselect();
        logic [DW-1:0] d;
        idle(); l_we_n = 0; l_addr = 13'h0123; l_wdata = 8'hFF;  // en_n stays high
        #1 chk("R3 left standby", l_stby, 1);
        step();
        chk("R3 no drive when deselected", {l_rdoe, l_rdata}, 0);
        rd(0, 13'h0123, d); chk("R3 deselected write ignored", d, 8'hA5);
    endtask

    task automatic t_oe_off();
        idle(); l_en_n = 0; l_addr = 13'h0123; step();
        chk("R4 no drive with output disabled", {l_rdoe, l_rdata}, 0);
        chk("R3 selected port not in standby", l_stby, 0);
        idle();
    endtask

    task automatic t_box_left();
        logic [DW-1:0] d;
        wr(1, BOX_L, 8'h77, 1);
        chk("R5 left irq set by right write", l_irq_n, 0);
        chk("R5 right irq untouched", r_irq_n, 1);
        chk("R11 no irq without mailbox", {l_irq_n1, r_irq_n1}, 2'b11);
        rd(1, BOX_L, d);
        chk("R7 box data stored", d, 8'h77);
        chk("R7 sender read keeps flag", l_irq_n, 0);
        rd(0, BOX_L, d);
        chk("R5 left read returns box data", d, 8'h77);
        chk("R5 left read clears irq", l_irq_n, 1);
        chk("R11 box is plain memory", l_rdata1, 8'h77);
        wr(0, BOX_L, 8'h21, 1);
        chk("R7 own-box write sets nothing", {l_irq_n, r_irq_n}, 2'b11);
        wr(0, BOX_L, 8'h77, 1);
    endtask

    task automatic t_box_right();
        logic [DW-1:0] d;
        wr(0, BOX_R, 8'h99, 1);
        chk("R6 right irq set by left write", r_irq_n, 0);
        chk("R6 left irq untouched", l_irq_n, 1);
        rd(1, BOX_R, d);
        chk("R6 right read returns box data", d, 8'h99);
        chk("R6 right read clears irq", r_irq_n, 1);
        chk("R11 no irq without mailbox", r_irq_n1, 1);
    endtask

    task automatic t_block();
        logic [DW-1:0] d;
        wr(0, 13'h0200, 8'h11, 1);
        wr(0, 13'h0200, 8'h22, 0);
        rd(0, 13'h0200, d); chk("R8 blocked write ignored", d, 8'h11);
        wr(0, BOX_R, 8'h55, 0);
        chk("R8 blocked box write leaves irq", r_irq_n, 1);
        rd(1, BOX_R, d); chk("R8 blocked box write leaves data", d, 8'h99);
    endtask

    task automatic t_collide();
        logic [DW-1:0] d;
        idle(); set_wr(0, 13'h0300, 8'hAA, 1); set_wr(1, 13'h0300, 8'hBB, 1); step(); idle();
        rd(1, 13'h0300, d); chk("R9 left wins same-address write", d, 8'hAA);
    endtask

    task automatic t_set_clear();
        logic [DW-1:0] d;
        wr(1, BOX_L, 8'h10, 1);
        chk("R5 left irq set", l_irq_n, 0);
        idle(); set_wr(1, BOX_L, 8'h44, 1); set_rd(0, BOX_L); step();
        chk("R12 read beside write sees old word", l_rdata, 8'h10);
        chk("R10 set wins over clear", l_irq_n, 0);
        chk("R11 old word without mailbox", l_rdata1, 8'h10);
        idle();
        rd(0, BOX_L, d);
        chk("R10 later read gets new word", d, 8'h44);
        chk("R10 later read clears irq", l_irq_n, 1);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_basic();
        t_deselect();
        t_oe_off();
        t_box_left();
        t_box_right();
        t_block();
        t_collide();
        t_set_clear();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule